// File: doc/BRIEF.md
# Key-Locked Pad Delay Register Bank

This block is a memory-mapped bank of 32-bit registers that stores the delay-element settings for a row of I/O pads. The settings can only be changed after a 16-bit key has opened the bank. Each pad owns three consecutive configuration words. Every configuration word carries three fields:

- a coarse element count,
- a fine element count,
- a sticky lock bit.

A write is only taken if it also carries a fixed signature value. The coarse and fine counts of every configuration word are driven continuously out of the block toward the delay-line logic.

Three read-only words give software the calibration results that the delay-line calibration logic supplies on input ports:

- a reference clock period;
- a coarse calibration word, with the delay count in bits 31:16 and the reference count in bits 15:0;
- a fine calibration word, with the same layout.

Software reads these words, derives the element counts, opens the bank with the key, writes the configuration words, and may close the bank again.

The request channel is valid/ready. The bank never applies back-pressure, so `req_ready` is always high and a request is accepted in every cycle in which `req_valid` is high. Each accepted request produces exactly one response cycle, flagged by `rsp_valid`, on the next clock edge. The response cannot be stalled, so a requester must take it in that cycle. Byte offsets are used on `req_addr`, and bits 1:0 of the address are ignored.

Top module: `pad_delay_bank`

## Requirements
- R1: After reset the bank is closed, every configuration word reads zero, and every exported element count is zero.
- R2: The key word at offset 0x2C reads 0x0000AAAA while the bank is open and 0x0000AAAB while it is closed. Writing 0xAAAA to its low 16 bits opens the bank, writing 0xAAAB closes it, and any other value leaves the state unchanged.
- R3: Configuration word k sits at offset 0x30 + 4*k for k below 3*NUM_PADS, so the last word is at 0xD1C for 276 pads. It reads back with the signature in bits 17:12, the lock bit in bit 10, the coarse count in bits 9:5, the fine count in bits 4:0, and zeros everywhere else.
- R4: While the bank is closed, a write to a configuration word changes nothing.
- R5: A configuration write whose bits 17:12 differ from 0x29 is dropped.
- R6: If the stored lock bit of a word is 1, a write to that word is dropped, with one exception. While the bank is open, a write with a valid signature and bit 10 = 0 clears the lock bit only, and the other stored fields keep their values.
- R7: Offset 0x14 reads {16'h0, cal_ref_period}, offset 0x18 reads cal_coarse_word, and offset 0x1C reads cal_fine_word. Writes to these three offsets are ignored.
- R8: The unmapped offsets are any offset below 0x30 other than 0x14, 0x18, 0x1C and 0x2C, and any offset beyond the last configuration word. An access to one of them returns data zero with rsp_err = 1 and changes nothing. Mapped accesses return rsp_err = 0.
- R9: rsp_valid is high exactly in the cycle after each accepted request and low otherwise. Writes return rsp_rdata = 0.
- R10: elem_coarse[5k+4:5k] and elem_fine[5k+4:5k] carry the coarse and fine counts of configuration word k, and they update on the same edge that accepts the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (always high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the word |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response cycle, one edge after acceptance |
| rsp_rdata | output | 32 | Read data (zero for writes and errors) |
| rsp_err | output | 1 | Unmapped offset |
| cal_ref_period | input | 16 | Calibrated reference clock period |
| cal_coarse_word | input | 32 | Coarse calibration counts |
| cal_fine_word | input | 32 | Fine calibration counts |
| elem_coarse | output | NUM_REGS*5 | Coarse counts of all configuration words |
| elem_fine | output | NUM_REGS*5 | Fine counts of all configuration words |

## Verification
A request driven before a rising edge is accepted on that edge. Its response, any change of key state, any configuration word and any exported count are all updated by that same edge. The bench therefore drives on a falling edge and samples the response, and the export of the word just written, on the next falling edge. One further falling edge later it checks that `rsp_valid` has dropped again. Writes that should have no effect are checked by reading the word back, and by inspecting its exported counts, in the next transaction.

// File: rtl/pdb_pkg.sv
package pdb_pkg;
  localparam int unsigned OFS_PERIOD  = 32'h014;
  localparam int unsigned OFS_CAL_C   = 32'h018;
  localparam int unsigned OFS_CAL_F   = 32'h01C;
  localparam int unsigned OFS_KEY     = 32'h02C;
  localparam int unsigned CFG_BASE    = 32'h030;

  localparam int unsigned ELEM_W      = 5;
  localparam int unsigned SIG_W       = 6;
  localparam logic [SIG_W-1:0] SIG_GOOD = 6'h29;
  localparam logic [15:0] KEY_OPEN    = 16'hAAAA;
  localparam logic [15:0] KEY_SHUT    = 16'hAAAB;

  typedef enum logic [2:0] {
    RG_NONE,
    RG_PERIOD,
    RG_CAL_C,
    RG_CAL_F,
    RG_KEY,
    RG_CFG
  } region_e;

  typedef struct packed {
    logic [SIG_W-1:0]  sig;
    logic              lock;
    logic [ELEM_W-1:0] coarse;
    logic [ELEM_W-1:0] fine;
  } cfg_word_t;

  function automatic cfg_word_t unpack_cfg(input logic [31:0] w);
    cfg_word_t c;
    c.sig    = w[17:12];
    c.lock   = w[10];
    c.coarse = w[9:5];
    c.fine   = w[4:0];
    return c;
  endfunction

  function automatic logic [31:0] pack_cfg(input cfg_word_t c);
    return {14'h0, c.sig, 1'b0, c.lock, c.coarse, c.fine};
  endfunction
endpackage

// File: rtl/pdb_decode.sv
module pdb_decode
  import pdb_pkg::*;
#(
  parameter int AW       = 12,
  parameter int NUM_REGS = 828,
  parameter int IDXW     = 10
) (
  input  logic [AW-1:0]   addr,
  output region_e         region,
  output logic [IDXW-1:0] idx
);
  localparam logic [AW-1:0] A_PERIOD = AW'(OFS_PERIOD);
  localparam logic [AW-1:0] A_CAL_C  = AW'(OFS_CAL_C);
  localparam logic [AW-1:0] A_CAL_F  = AW'(OFS_CAL_F);
  localparam logic [AW-1:0] A_KEY    = AW'(OFS_KEY);
  localparam logic [AW-1:0] A_LO     = AW'(CFG_BASE);
  localparam logic [AW-1:0] A_HI     = AW'(CFG_BASE + 4 * (NUM_REGS - 1));

  logic [AW-1:0] aligned;
  logic [AW-1:0] off;
  logic          unused_bits;

  assign aligned     = {addr[AW-1:2], 2'b00};
  assign off         = aligned - A_LO;
  assign idx         = off[IDXW+1:2];
  assign unused_bits = ^{addr[1:0], off[1:0], off[AW-1:IDXW+2]};

  always_comb begin
    region = RG_NONE;
    if (aligned == A_PERIOD)                      region = RG_PERIOD;
    else if (aligned == A_CAL_C)                  region = RG_CAL_C;
    else if (aligned == A_CAL_F)                  region = RG_CAL_F;
    else if (aligned == A_KEY)                    region = RG_KEY;
    else if (aligned >= A_LO && aligned <= A_HI)  region = RG_CFG;
  end
endmodule

// File: rtl/pdb_key.sv
module pdb_key
  import pdb_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [15:0] wkey,
  output logic        open
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open <= 1'b0;
    end else if (wr_en) begin
      if (wkey == KEY_OPEN)      open <= 1'b1;
      else if (wkey == KEY_SHUT) open <= 1'b0;
    end
  end
endmodule

// File: rtl/pdb_cfg_array.sv
module pdb_cfg_array
  import pdb_pkg::*;
#(
  parameter int NUM_REGS = 828,
  parameter int IDXW     = 10
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [IDXW-1:0]            idx,
  input  cfg_word_t                  wr_val,
  output cfg_word_t                  rd_val,
  output logic [NUM_REGS*ELEM_W-1:0] elem_coarse,
  output logic [NUM_REGS*ELEM_W-1:0] elem_fine
);
  localparam logic [IDXW-1:0] IDX_END = IDXW'(NUM_REGS);

  cfg_word_t ent_q [NUM_REGS];
  logic      sig_ok;

  assign rd_val = (idx < IDX_END) ? ent_q[idx] : '0;
  assign sig_ok = (wr_val.sig == SIG_GOOD);

  // Sticky lock: a locked word only accepts a signed write that clears the lock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) ent_q[i] <= '0;
    end else if (wr_en && idx < IDX_END) begin
      if (!ent_q[idx].lock) begin
        if (sig_ok) ent_q[idx] <= wr_val;
      end else if (sig_ok && !wr_val.lock) begin
        ent_q[idx].lock <= 1'b0;
      end
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_export
    assign elem_coarse[g*ELEM_W +: ELEM_W] = ent_q[g].coarse;
    assign elem_fine[g*ELEM_W +: ELEM_W]   = ent_q[g].fine;
  end
endmodule

// File: rtl/pad_delay_bank.sv
module pad_delay_bank
  import pdb_pkg::*;
#(
  parameter int NUM_PADS     = 276,
  parameter int REGS_PER_PAD = 3,
  localparam int NUM_REGS    = NUM_PADS * REGS_PER_PAD,
  localparam int ADDR_W      = $clog2(CFG_BASE + 4 * NUM_REGS),
  localparam int IDXW        = $clog2(NUM_REGS + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic                       req_write,
  input  logic [ADDR_W-1:0]          req_addr,
  input  logic [31:0]                req_wdata,
  output logic                       rsp_valid,
  output logic [31:0]                rsp_rdata,
  output logic                       rsp_err,
  input  logic [15:0]                cal_ref_period,
  input  logic [31:0]                cal_coarse_word,
  input  logic [31:0]                cal_fine_word,
  output logic [NUM_REGS*ELEM_W-1:0] elem_coarse,
  output logic [NUM_REGS*ELEM_W-1:0] elem_fine
);
  region_e         region;
  logic [IDXW-1:0] idx;
  logic            bank_open;
  cfg_word_t       cfg_rd;
  logic            acc_wr;
  logic [31:0]     rd_mux;
  logic            unused_wdata;

  assign req_ready    = 1'b1;
  assign acc_wr       = req_valid && req_write;
  assign unused_wdata = ^{req_wdata[31:18], req_wdata[11]};

  pdb_decode #(.AW(ADDR_W), .NUM_REGS(NUM_REGS), .IDXW(IDXW)) u_dec (
    .addr   (req_addr),
    .region (region),
    .idx    (idx)
  );

  pdb_key u_key (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (acc_wr && region == RG_KEY),
    .wkey  (req_wdata[15:0]),
    .open  (bank_open)
  );

  pdb_cfg_array #(.NUM_REGS(NUM_REGS), .IDXW(IDXW)) u_cfg (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (acc_wr && region == RG_CFG && bank_open),
    .idx         (idx),
    .wr_val      (unpack_cfg(req_wdata)),
    .rd_val      (cfg_rd),
    .elem_coarse (elem_coarse),
    .elem_fine   (elem_fine)
  );

  always_comb begin
    unique case (region)
      RG_PERIOD: rd_mux = {16'h0, cal_ref_period};
      RG_CAL_C:  rd_mux = cal_coarse_word;
      RG_CAL_F:  rd_mux = cal_fine_word;
      RG_KEY:    rd_mux = {16'h0, bank_open ? KEY_OPEN : KEY_SHUT};
      RG_CFG:    rd_mux = pack_cfg(cfg_rd);
      default:   rd_mux = 32'h0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= 32'h0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_rdata <= (req_valid && !req_write) ? rd_mux : 32'h0;
      rsp_err   <= req_valid && (region == RG_NONE);
    end
  end
endmodule

// File: rtl/pdb_checker.sv
module pdb_checker
  import pdb_pkg::*;
#(
  parameter int NUM_REGS = 828,
  parameter int ADDR_W   = 12
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       req_valid,
  input logic                       req_write,
  input logic [ADDR_W-1:0]          req_addr,
  input logic                       rsp_valid,
  input logic [31:0]                rsp_rdata,
  input logic                       rsp_err,
  input logic                       bank_open,
  input logic [NUM_REGS*ELEM_W-1:0] elem_coarse,
  input logic [NUM_REGS*ELEM_W-1:0] elem_fine
);
  localparam logic [ADDR_W-3:0] KEY_WORD = (ADDR_W-2)'(OFS_KEY >> 2);

  p_reset_closed_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> !bank_open);

  p_key_only_by_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bank_open) |-> $past(req_valid && req_write && req_addr[ADDR_W-1:2] == KEY_WORD));

  p_closed_no_change_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !bank_open |=> ($stable(elem_coarse) && $stable(elem_fine)));

  p_err_reads_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_valid && rsp_rdata == 32'h0));

  p_rsp_follows_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  p_no_spurious_rsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
endmodule

bind pad_delay_bank pdb_checker #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_write   (req_write),
  .req_addr    (req_addr),
  .rsp_valid   (rsp_valid),
  .rsp_rdata   (rsp_rdata),
  .rsp_err     (rsp_err),
  .bank_open   (bank_open),
  .elem_coarse (elem_coarse),
  .elem_fine   (elem_fine)
);

// File: tb/sim_pad_delay_bank.sv
`timescale 1ns/1ps
module sim_pad_delay_bank;
  localparam int NP = 276;
  localparam int NR = NP * 3;
  localparam int AW = 12;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            req_valid = 1'b0;
  logic            req_ready;
  logic            req_write = 1'b0;
  logic [AW-1:0]   req_addr = '0;
  logic [31:0]     req_wdata = '0;
  logic            rsp_valid;
  logic [31:0]     rsp_rdata;
  logic            rsp_err;
  logic [15:0]     cal_ref_period = 16'h1388;
  logic [31:0]     cal_coarse_word = 32'h0123_4567;
  logic [31:0]     cal_fine_word = 32'h89AB_CDEF;
  logic [NR*5-1:0] elem_coarse;
  logic [NR*5-1:0] elem_fine;

  always #4 clk = ~clk;

  pad_delay_bank #(.NUM_PADS(NP)) u0 (.*);

  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;
  logic        m_open;
  logic [31:0] m_cfg [NR];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // 0 none, 1 period, 2 coarse cal, 3 fine cal, 4 key, 5 cfg
  function automatic int m_region(input logic [AW-1:0] a);
    logic [AW-1:0] w = {a[AW-1:2], 2'b00};
    if (w == 12'h014) return 1;
    if (w == 12'h018) return 2;
    if (w == 12'h01C) return 3;
    if (w == 12'h02C) return 4;
    if (w >= 12'h030 && w <= 12'h030 + 12'(4 * (NR - 1))) return 5;
    return 0;
  endfunction

  function automatic int m_idx(input logic [AW-1:0] a);
    return (int'({a[AW-1:2], 2'b00}) - 32'h30) / 4;
  endfunction

  function automatic logic [31:0] m_read(input logic [AW-1:0] a);
    case (m_region(a))
      1: return {16'h0, cal_ref_period};
      2: return cal_coarse_word;
      3: return cal_fine_word;
      4: return m_open ? 32'h0000AAAA : 32'h0000AAAB;
      5: return m_cfg[m_idx(a)];
      default: return 32'h0;
    endcase
  endfunction

  task automatic m_write(input logic [AW-1:0] a, input logic [31:0] d);
    int r = m_region(a);
    if (r == 4) begin
      if (d[15:0] == 16'hAAAA) m_open = 1'b1;
      else if (d[15:0] == 16'hAAAB) m_open = 1'b0;
    end else if (r == 5 && m_open) begin
      int k = m_idx(a);
      bit ok = (d[17:12] == 6'h29);
      if (!m_cfg[k][10]) begin
        if (ok) m_cfg[k] = d & 32'h0003F7FF;
      end else if (ok && !d[10]) begin
        m_cfg[k][10] = 1'b0;
      end
    end
  endtask

  task automatic acc(input string tag, input bit w, input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    check("R9 idle", {31'h0, rsp_valid}, 32'h0);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    @(negedge clk);
    check("R9 valid", {31'h0, rsp_valid}, 32'h1);
    check("R8 err", {31'h0, rsp_err}, {31'h0, m_region(a) == 0});
    check(tag, rsp_rdata, w ? 32'h0 : m_read(a));
    if (w) m_write(a, d);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic chk_elem(input string tag, input int k);
    check(tag, {27'h0, elem_coarse[5*k +: 5]}, {27'h0, m_cfg[k][9:5]});
    check(tag, {27'h0, elem_fine[5*k +: 5]}, {27'h0, m_cfg[k][4:0]});
  endtask

  function automatic logic [AW-1:0] cfg_addr(input int k);
    return 12'(32'h30 + 4 * k);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    m_open = 1'b0;
    for (int i = 0; i < NR; i++) m_cfg[i] = 32'h0;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    acc("R1 key closed", 1'b0, 12'h02C, 0);
    acc("R1 cfg first zero", 1'b0, cfg_addr(0), 0);
    acc("R1 cfg last zero", 1'b0, cfg_addr(NR - 1), 0);
    check("R1 exports zero", {31'h0, (elem_coarse == '0) && (elem_fine == '0)}, 32'h1);

    // R4 closed bank
    acc("R4 write", 1'b1, cfg_addr(0), 32'h0002_90E3);
    acc("R4 no effect", 1'b0, cfg_addr(0), 0);
    chk_elem("R4 export", 0);

    // R2 key
    acc("R2 open", 1'b1, 12'h02C, 32'hFFFF_AAAA);
    acc("R2 reads open", 1'b0, 12'h02C, 0);
    acc("R2 other", 1'b1, 12'h02C, 32'h0000_1234);
    acc("R2 still open", 1'b0, 12'h02C, 0);

    // R3 / R10 layout and export
    acc("R3 write", 1'b1, cfg_addr(0), 32'hFFFC_F8E3);
    acc("R3 readback", 1'b0, cfg_addr(0), 0);
    chk_elem("R10 export", 0);
    acc("R3 last", 1'b1, cfg_addr(NR - 1), 32'h0002_93FF);
    chk_elem("R10 export last", NR - 1);
    acc("R3 last read", 1'b0, 12'hD1C, 0);

    // R5 bad signature
    acc("R5 write", 1'b1, cfg_addr(0), 32'h0002_8021);
    acc("R5 dropped", 1'b0, cfg_addr(0), 0);

    // R6 lock bit
    acc("R6 lock set", 1'b1, cfg_addr(5), 32'h0002_94A1);
    acc("R6 stored", 1'b0, cfg_addr(5), 0);
    acc("R6 blocked", 1'b1, cfg_addr(5), 32'h0002_97FF);
    acc("R6 still", 1'b0, cfg_addr(5), 0);
    acc("R6 clear", 1'b1, cfg_addr(5), 32'h0002_93FF);
    acc("R6 cleared only", 1'b0, cfg_addr(5), 0);
    check("R6 fields kept", m_cfg[5], 32'h0002_90A1);
    chk_elem("R6 export", 5);
    acc("R6 normal", 1'b1, cfg_addr(5), 32'h0002_9042);
    acc("R6 after", 1'b0, cfg_addr(5), 0);

    // R7 calibration
    acc("R7 period", 1'b0, 12'h014, 0);
    acc("R7 coarse", 1'b0, 12'h018, 0);
    acc("R7 wr ignored", 1'b1, 12'h018, 32'hDEAD_BEEF);
    acc("R7 coarse kept", 1'b0, 12'h018, 0);
    acc("R7 fine", 1'b0, 12'h01C, 0);

    // R8 unmapped
    acc("R8 beyond", 1'b0, 12'hD20, 0);
    acc("R8 low", 1'b0, 12'h010, 0);
    acc("R8 gap", 1'b0, 12'h020, 0);
    acc("R8 wr", 1'b1, 12'hFFC, 32'h0002_9021);

    // R4 close again
    acc("R2 close", 1'b1, 12'h02C, 32'h0000_AAAB);
    acc("R4 closed wr", 1'b1, cfg_addr(0), 32'h0002_9000);
    acc("R4 closed kept", 1'b0, cfg_addr(0), 0);

    // random mix
    for (int n = 0; n < 1500; n++) begin
      int sel = $urandom_range(0, 99);
      logic [31:0] d = $urandom;
      if ($urandom_range(0, 3) != 0) d[17:12] = 6'h29;
      if ($urandom_range(0, 4) != 0) d[10] = 1'b0;
      if (sel < 10) begin
        case ($urandom_range(0, 2))
          0: d[15:0] = 16'hAAAA;
          1: d[15:0] = 16'hAAAB;
          default: ;
        endcase
        acc("R2 rnd", $urandom_range(0, 1) == 1, 12'h02C, d);
      end else if (sel < 70) begin
        int k = $urandom_range(0, NR - 1);
        bit w = $urandom_range(0, 1) == 1;
        acc("R3 rnd", w, cfg_addr(k), d);
        chk_elem("R10 rnd", k);
      end else if (sel < 80) begin
        @(negedge clk);
        cal_ref_period = 16'($urandom);
        cal_coarse_word = $urandom;
        acc("R7 rnd", $urandom_range(0, 1) == 1, 12'h014 + 12'(4 * $urandom_range(0, 2)), d);
      end else begin
        logic [AW-1:0] a = 12'($urandom_range(0, 4095));
        acc(m_region(a) == 0 ? "R8 rnd" : "R3 rnd mapped", $urandom_range(0, 1) == 1, a, d);
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule